// File: doc/BRIEF.md
# Per-Monitor Access Trap Filter

This block decides, for each access that lower-privilege software makes to the registers of one system performance monitor instance, whether that access must be diverted to the hypervisor level. It holds a control word with one two-bit policy field for each of the monitor instances. The policy can trap every access, trap only writes, or let everything through. A request carries the privilege level, a read/write flag, the monitor index and two qualifiers. One qualifier says whether the hypervisor level is present and enabled in the current security state. The other says whether the same instruction already raises an exception of higher priority.

Each valid request gets exactly one answer one clock later. The answer is a single-cycle trap strobe or a single-cycle allow strobe. A separate flag goes up with the answer when the policy that was consulted holds the reserved encoding. Software loads the whole control word through a plain write port. Exception delivery, syndrome formatting and the monitors themselves belong to other blocks.

Top module: `pmon_trap_filter`

## Requirements
- R1: While reset is held, and in the cycle after it, the control word is all zeros and both strobes and the reserved flag are low. After reset, any read or write to any monitor from level 0 or 1 traps.
- R2: A field of value 2'b00 traps both reads and writes from level 0 and level 1.
- R3: A field of value 2'b01 traps writes from level 0 and level 1 and allows reads.
- R4: A field of value 2'b11 allows both reads and writes.
- R5: A field of value 2'b10 behaves like 2'b00. The `reserved_seen` output pulses together with the trap strobe of every request that consulted such a field.
- R6: When `hyp_enabled` is low the fields are ignored: the request is allowed and `reserved_seen` stays low.
- R7: When `higher_prio_exc` is high the request is allowed and `reserved_seen` stays low, whatever the field holds.
- R8: Requests from level 2 or level 3 (`req_el` = 2 or 3) are always allowed.
- R9: For each cycle with `req_valid` high, exactly one of `trap` and `allow` is high for one cycle, in the cycle after the request. Both are low after a cycle without a request.
- R10: Monitor m is governed by control bits [2m+1:2m]. A word written with `cfg_we` governs requests from the next cycle on. A request presented in the same cycle as the write still sees the previous word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Load the control word |
| cfg_wdata | input | 64 | New control word, two bits per monitor |
| req_valid | input | 1 | An access request is present this cycle |
| req_el | input | 2 | Privilege level of the access, 0 to 3 |
| req_is_write | input | 1 | 1 for a register write, 0 for a read |
| req_mon | input | 5 | Index of the monitor instance addressed |
| hyp_enabled | input | 1 | Hypervisor level implemented and enabled in this security state |
| higher_prio_exc | input | 1 | The instruction already raises a higher-priority exception |
| trap | output | 1 | Pulse: divert the access to the hypervisor level |
| allow | output | 1 | Pulse: the access proceeds |
| reserved_seen | output | 1 | Pulse with `trap` when the consulted field held 2'b10 |

## Verification
A corrupted bit in the control word shows up as a wrong strobe on the very next request that addresses the affected monitor from level 0 or 1. A read can expose the low bit of a field, and a write exposes the difference between trapping and allowing. The bench therefore walks every monitor index with mixed field values and both access directions, so that a misplaced slice or a wrong index decode shows within one response cycle. A wrong qualifier priority (hypervisor disabled, higher exception, high privilege level) appears as a trap where an allow is expected, in the cycle after that request. A lost or doubled response would show up as both strobes low, or both high, at that same sample point.

// File: rtl/pmon_trap_pkg.sv
// Shared types for the per-monitor access trap filter.
// Assumes two-bit policy fields; the encodings below are fixed by behaviour.
package pmon_trap_pkg;

    typedef enum logic [1:0] {
        POL_TRAP_ALL   = 2'b00,
        POL_TRAP_WRITE = 2'b01,
        POL_RESERVED   = 2'b10,
        POL_OPEN       = 2'b11
    } policy_e;

    localparam int unsigned POL_W = 2;

endpackage

// File: rtl/pmon_ctrl_word.sv
// Control word storage for the trap filter.
// Holds one policy field per monitor; a full-word write replaces all fields.
// Assumes synchronous active-low reset clearing every field to trap-all.
module pmon_ctrl_word #(
    parameter int unsigned NUM_MON = 32,
    parameter int unsigned POL_W   = 2,
    localparam int unsigned WORD_W = NUM_MON * POL_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [WORD_W-1:0] wdata,
    output logic [WORD_W-1:0] word
);

    // Store the control word; cleared on reset, replaced on write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            word <= '0;
        end else if (we) begin
            word <= wdata;
        end
    end

    // R1: the word is all zeros in the cycle after reset was held
    a_r1_reset_clear: assert property (@(posedge clk)
        $past(!rst_n) |-> (word == '0));

    // R10: a write is visible in the following cycle
    a_r10_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && $past(we) |-> (word == $past(wdata)));

endmodule

// File: rtl/pmon_field_select.sv
// Picks the policy field for one monitor out of the packed control word.
// Assumes monitor m occupies bits [POL_W*m+POL_W-1 : POL_W*m].
module pmon_field_select #(
    parameter int unsigned NUM_MON = 32,
    parameter int unsigned POL_W   = 2,
    localparam int unsigned WORD_W = NUM_MON * POL_W,
    localparam int unsigned IDX_W  = (NUM_MON > 1) ? $clog2(NUM_MON) : 1
) (
    input  logic [WORD_W-1:0] word,
    input  logic [IDX_W-1:0]  idx,
    output logic [POL_W-1:0]  field
);

    logic [POL_W-1:0] fields [NUM_MON];

    // Unpack the word into one slot per monitor.
    for (genvar g = 0; g < NUM_MON; g++) begin : g_slice
        assign fields[g] = word[g*POL_W +: POL_W];
    end

    // Select the addressed monitor's field.
    always_comb begin
        field = fields[idx];
    end

endmodule

// File: rtl/pmon_trap_decide.sv
// Combinational trap decision for a single access.
// Assumes levels 2 and 3 are never filtered, and that a disabled hypervisor
// or a higher-priority exception suppresses any trap.
module pmon_trap_decide
    import pmon_trap_pkg::*;
(
    input  logic [1:0]       el,
    input  logic             is_write,
    input  logic             hyp_en,
    input  logic             hp_exc,
    input  logic [POL_W-1:0] field,
    output logic             do_trap,
    output logic             hit_reserved
);

    logic    consulted;
    policy_e pol;

    // Field applies only to levels 0/1 with hypervisor on and no prior exception.
    always_comb begin
        consulted = (el < 2'd2) && hyp_en && !hp_exc;
        pol       = policy_e'(field);
    end

    // Map the policy to a trap decision; reserved acts as trap-all.
    always_comb begin
        do_trap      = 1'b0;
        hit_reserved = 1'b0;
        if (consulted) begin
            unique case (pol)
                POL_TRAP_ALL:   do_trap = 1'b1;
                POL_TRAP_WRITE: do_trap = is_write;
                POL_RESERVED: begin
                    do_trap      = 1'b1;
                    hit_reserved = 1'b1;
                end
                POL_OPEN:       do_trap = 1'b0;
                default:        do_trap = 1'b1;
            endcase
        end
    end

endmodule

// File: rtl/pmon_trap_filter.sv
// Top of the per-monitor access trap filter.
// Each valid request yields one registered trap or allow pulse a cycle later.
// Assumes requests and control writes are synchronous to clk.
module pmon_trap_filter
    import pmon_trap_pkg::*;
#(
    parameter int unsigned NUM_MON = 32,
    localparam int unsigned WORD_W = NUM_MON * POL_W,
    localparam int unsigned IDX_W  = (NUM_MON > 1) ? $clog2(NUM_MON) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [WORD_W-1:0] cfg_wdata,
    input  logic              req_valid,
    input  logic [1:0]        req_el,
    input  logic              req_is_write,
    input  logic [IDX_W-1:0]  req_mon,
    input  logic              hyp_enabled,
    input  logic              higher_prio_exc,
    output logic              trap,
    output logic              allow,
    output logic              reserved_seen
);

    logic [WORD_W-1:0] word;
    logic [POL_W-1:0]  field;
    logic              dec_trap;
    logic              dec_rsv;

    pmon_ctrl_word #(.NUM_MON(NUM_MON), .POL_W(POL_W)) u_ctrl (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (cfg_we),
        .wdata (cfg_wdata),
        .word  (word)
    );

    pmon_field_select #(.NUM_MON(NUM_MON), .POL_W(POL_W)) u_sel (
        .word  (word),
        .idx   (req_mon),
        .field (field)
    );

    pmon_trap_decide u_dec (
        .el           (req_el),
        .is_write     (req_is_write),
        .hyp_en       (hyp_enabled),
        .hp_exc       (higher_prio_exc),
        .field        (field),
        .do_trap      (dec_trap),
        .hit_reserved (dec_rsv)
    );

    // Register the response strobes one cycle after the request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            trap          <= 1'b0;
            allow         <= 1'b0;
            reserved_seen <= 1'b0;
        end else begin
            trap          <= req_valid && dec_trap;
            allow         <= req_valid && !dec_trap;
            reserved_seen <= req_valid && dec_rsv;
        end
    end

    // R9: never both strobes at once
    a_r9_one_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({trap, allow}));

    // R9: a request is answered in the next cycle
    a_r9_answered: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> (trap || allow));

    // R9: no request, no answer
    a_r9_silent: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !(trap || allow || reserved_seen));

    // R8: high privilege levels pass
    a_r8_high_level: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && req_el[1] |=> allow);

    // R6: hypervisor off means allow and no reserved flag
    a_r6_hyp_off: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && !hyp_enabled |=> allow && !reserved_seen);

    // R7: a higher-priority exception suppresses the trap
    a_r7_prior_exc: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && higher_prio_exc |=> allow && !reserved_seen);

    // R5: reserved flag only accompanies a trap
    a_r5_rsv_with_trap: assert property (@(posedge clk) disable iff (!rst_n)
        reserved_seen |-> trap);

endmodule

// File: tb/pmon_trap_filter_tb.sv
// Directed bench for the per-monitor access trap filter.
module pmon_trap_filter_tb;

    localparam int NUM_MON = 32;
    localparam int WORD_W  = 64;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              cfg_we = 1'b0;
    logic [WORD_W-1:0] cfg_wdata = '0;
    logic              req_valid = 1'b0;
    logic [1:0]        req_el = 2'd0;
    logic              req_is_write = 1'b0;
    logic [4:0]        req_mon = 5'd0;
    logic              hyp_enabled = 1'b1;
    logic              higher_prio_exc = 1'b0;
    logic              trap, allow, reserved_seen;

    int total = 0;
    int bad = 0;
    logic [WORD_W-1:0] mdl = '0;

    always #10 clk = ~clk;   // 50 MHz

    pmon_trap_filter #(.NUM_MON(NUM_MON)) u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
        .req_valid(req_valid), .req_el(req_el), .req_is_write(req_is_write),
        .req_mon(req_mon), .hyp_enabled(hyp_enabled),
        .higher_prio_exc(higher_prio_exc), .trap(trap), .allow(allow),
        .reserved_seen(reserved_seen)
    );

    task automatic check3(string tag, logic t, logic a, logic r,
                          logic et, logic ea, logic er);
        total++;
        if (t !== et || a !== ea || r !== er) begin
            bad++;
            $display("FAIL %s: trap/allow/rsv got %b%b%b expected %b%b%b",
                     tag, t, a, r, et, ea, er);
        end
    endtask

    function automatic logic [1:0] exp_resp(logic [WORD_W-1:0] w, int el,
                                            logic wr, int mon, logic hyp,
                                            logic hp);
        logic [1:0] f;
        if (el >= 2 || !hyp || hp) return 2'b00;   // {trap, rsv}
        f = w[2*mon +: 2];
        case (f)
            2'b00: return 2'b10;
            2'b01: return {wr, 1'b0};
            2'b10: return 2'b11;
            default: return 2'b00;
        endcase
    endfunction

    task automatic write_word(logic [WORD_W-1:0] w);
        @(negedge clk);
        cfg_we = 1'b1; cfg_wdata = w;
        @(negedge clk);
        cfg_we = 1'b0;
        mdl = w;
    endtask

    // Drive one request at a falling edge, sample just after the next rising edge.
    task automatic do_req(string tag, int el, logic wr, int mon, logic hyp, logic hp);
        logic [1:0] e;
        @(negedge clk);
        req_valid = 1'b1; req_el = 2'(el); req_is_write = wr;
        req_mon = 5'(mon); hyp_enabled = hyp; higher_prio_exc = hp;
        e = exp_resp(mdl, el, wr, mon, hyp, hp);
        @(posedge clk); #1;
        check3(tag, trap, allow, reserved_seen, e[1], !e[1], e[0]);
        @(negedge clk);
        req_valid = 1'b0; hyp_enabled = 1'b1; higher_prio_exc = 1'b0;
    endtask

    task automatic t_reset;   // R1
        @(posedge clk); #1;
        check3("R1 in reset", trap, allow, reserved_seen, 0, 0, 0);
        @(negedge clk); rst_n = 1'b1;
        @(posedge clk); #1;
        check3("R1 after reset", trap, allow, reserved_seen, 0, 0, 0);
        mdl = '0;
        do_req("R1 read traps", 1, 1'b0, 7, 1'b1, 1'b0);
        do_req("R1 write traps", 0, 1'b1, 31, 1'b1, 1'b0);
    endtask

    task automatic t_codes;   // R2 R3 R4 R5 R10
        logic [WORD_W-1:0] w;
        w = '0;
        for (int m = 0; m < NUM_MON; m++) w[2*m +: 2] = 2'((m * 3 + 1) % 4);
        write_word(w);
        for (int m = 0; m < NUM_MON; m++) begin
            do_req("R10 field walk rd", m % 2, 1'b0, m, 1'b1, 1'b0);
            do_req("R10 field walk wr", (m + 1) % 2, 1'b1, m, 1'b1, 1'b0);
        end
        write_word({NUM_MON{2'b00}});
        do_req("R2 trap-all read", 1, 1'b0, 3, 1'b1, 1'b0);
        do_req("R2 trap-all write", 0, 1'b1, 3, 1'b1, 1'b0);
        write_word({NUM_MON{2'b01}});
        do_req("R3 write-only read", 1, 1'b0, 9, 1'b1, 1'b0);
        do_req("R3 write-only write", 1, 1'b1, 9, 1'b1, 1'b0);
        write_word({NUM_MON{2'b11}});
        do_req("R4 open read", 0, 1'b0, 20, 1'b1, 1'b0);
        do_req("R4 open write", 1, 1'b1, 20, 1'b1, 1'b0);
        write_word({NUM_MON{2'b10}});
        do_req("R5 reserved read", 1, 1'b0, 0, 1'b1, 1'b0);
        do_req("R5 reserved write", 0, 1'b1, 31, 1'b1, 1'b0);
    endtask

    task automatic t_hyp_off;   // R6
        write_word({NUM_MON{2'b10}});
        do_req("R6 hyp off read", 1, 1'b0, 5, 1'b0, 1'b0);
        do_req("R6 hyp off write", 0, 1'b1, 5, 1'b0, 1'b0);
    endtask

    task automatic t_prior;   // R7
        write_word('0);
        do_req("R7 prior exc read", 0, 1'b0, 12, 1'b1, 1'b1);
        write_word({NUM_MON{2'b10}});
        do_req("R7 prior exc write", 1, 1'b1, 12, 1'b1, 1'b1);
    endtask

    task automatic t_high_el;   // R8
        write_word('0);
        do_req("R8 level 2 write", 2, 1'b1, 1, 1'b1, 1'b0);
        do_req("R8 level 3 read", 3, 1'b0, 30, 1'b1, 1'b0);
    endtask

    task automatic t_idle;   // R9
        @(negedge clk);
        req_valid = 1'b0;
        @(posedge clk); #1;
        check3("R9 idle", trap, allow, reserved_seen, 0, 0, 0);
        do_req("R9 answered", 1, 1'b1, 2, 1'b1, 1'b0);
        @(posedge clk); #1;
        check3("R9 single pulse", trap, allow, reserved_seen, 0, 0, 0);
    endtask

    task automatic t_same_cycle;   // R10
        logic [1:0] e;
        write_word('0);
        @(negedge clk);
        cfg_we = 1'b1; cfg_wdata = {NUM_MON{2'b11}};
        req_valid = 1'b1; req_el = 2'd1; req_is_write = 1'b0; req_mon = 5'd4;
        e = exp_resp(mdl, 1, 1'b0, 4, 1'b1, 1'b0);
        @(posedge clk); #1;
        check3("R10 same-cycle old word", trap, allow, reserved_seen, e[1], !e[1], e[0]);
        @(negedge clk);
        cfg_we = 1'b0; req_valid = 1'b0;
        mdl = {NUM_MON{2'b11}};
        do_req("R10 next-cycle new word", 1, 1'b0, 4, 1'b1, 1'b0);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        bad++; total++;
        $display("FAIL watchdog: run did not finish, got timeout expected completion");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin : main
        t_reset();
        t_codes();
        t_hyp_off();
        t_prior();
        t_high_el();
        t_idle();
        t_same_cycle();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule